// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block is the request-handling core of a four-channel DMA controller. Peripherals raise asynchronous request lines. The block synchronises them and asks the processor for the bus with a hold request. Once hold acknowledge arrives, it grants one enabled, requesting channel. It then runs one memory transfer cycle for that channel. Each cycle has an address phase and a strobe phase. In the address phase the low address byte is driven, and the upper byte is driven with an address strobe when an external latch must capture it. In the strobe phase the block drives an active-low memory read or memory write strobe, and it stays in that phase while READY is low.

A small programming port loads each channel's start address, transfer count and direction, and selects fixed or rotating priority. Every completed transfer advances the channel's address and count. The last transfer of a channel raises terminal count and disables that channel. When no enabled channel is still requesting, the hold request is released.

The block carries no data stream. All pins are plain control and status signals, so the block has no valid/ready back-pressure. READY is the only flow control, and it stretches the strobe phase.

Top module: `dma_req_arbiter`

## Requirements
- R1: Each request passes through a two-flop synchroniser. A request that is first high before clock edge 1 leaves `hrq` low after edges 1 and 2 and drives it high after edge 3.
- R2: While `hlda` is low, no `dack` bit and no memory strobe is asserted, even with `hrq` high.
- R3: In fixed mode (mode write with data bit 0 = 0) the lowest-numbered channel that is enabled and requesting is granted. A channel that is enabled but not requesting is never granted.
- R4: In rotating mode (data bit 0 = 1), after each transfer the channel just serviced becomes lowest priority and the channel above it becomes highest. Any mode write restarts the order with channel 0 highest.
- R5: `dack` is one-hot or zero. It marks only the granted channel during that channel's address cycle and strobe cycles. A memory strobe is low only while `dack` is nonzero, and never both strobes at once.
- R6: While a strobe is low and `ready` is low, the strobe, `dack` and `addr_lo` hold their values into the next cycle.
- R7: Programming field 0 loads a channel's 16-bit address. Each transfer increments the address by one and decrements the 14-bit count by one.
- R8: Programming field 1 loads the count (data bits 13:0) and enables the channel. `tc` is high only in the completing strobe cycle of a transfer made with count 0. The count then wraps and the channel is disabled.
- R9: `hrq` is low in the cycle after a completing transfer that leaves no enabled channel requesting.
- R10: `adstb` is high only in an address cycle, and it drives the upper address byte on `upper_out`. It is raised on the first address cycle after `hrq` rises, and again whenever the upper byte differs from the one last presented.
- R11: Bit 15 of a count write selects the direction. 1 gives memory write (`mem_wr_n` low) and 0 gives memory read (`mem_rd_n` low). Field codes 2 and 3 do not change any channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drq | input | 4 | Asynchronous per-channel DMA requests |
| hlda | input | 1 | Hold acknowledge from the processor |
| ready | input | 1 | Active-high; low inserts wait states |
| prog_we | input | 1 | Programming write enable |
| prog_chan | input | 2 | Channel addressed by the write |
| prog_field | input | 2 | 0 address, 1 count/direction, 2 mode |
| prog_wdata | input | 16 | Write data |
| hrq | output | 1 | Hold request to the processor |
| dack | output | 4 | Per-channel DMA acknowledge |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| addr_lo | output | 8 | Low address byte |
| upper_out | output | 8 | Upper address byte for the external latch |
| adstb | output | 1 | Upper-byte latch strobe |
| tc | output | 1 | Terminal count pulse |

## Verification
The arbiter is exercised with all four channels requesting in fixed mode, which shows strict ordering, and the same pattern in rotating mode, which shows the round-robin hand-off. Sparse request masks with enabled but silent channels show that only real requests are granted. A directed run crosses a 256-byte address boundary and mixes a single-transfer channel with a longer one, which separates the first-cycle upper-byte strobe from the boundary-crossing strobe and shows terminal count on the last transfer. Random masks, counts, directions and READY patterns follow. Each grant, address, strobe and terminal-count pulse is checked against a cycle model kept in the bench.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ADDR, ST_XFER} arb_state_t;
  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_MODE = 2'd2;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], async_in[g]};
    end
    assign sync_out[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [IW-1:0] base,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Scan starts at base and wraps; first pending channel wins.
  always_comb begin
    int c;
    any = 1'b0;
    idx = base;
    for (int i = 0; i < N; i++) begin
      c = (int'(base) + i) % N;
      if (!any && pend[c]) begin
        any = 1'b1;
        idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int CW = 14,
  parameter int DW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_chan,
  input  logic [1:0]           wr_field,
  input  logic [DW-1:0]        wr_data,
  input  logic                 step,
  input  logic [IW-1:0]        step_chan,
  output logic [N-1:0][AW-1:0] ch_addr,
  output logic [N-1:0][CW-1:0] ch_cnt,
  output logic [N-1:0]         ch_en,
  output logic [N-1:0]         ch_dir
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic hit, stp;
    assign hit = wr_en && (wr_chan == IW'(g));
    assign stp = step && (step_chan == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_addr[g] <= '0;
        ch_cnt[g]  <= '0;
        ch_en[g]   <= 1'b0;
        ch_dir[g]  <= 1'b0;
      end else begin
        if (hit && wr_field == FLD_ADDR) ch_addr[g] <= wr_data[AW-1:0];
        else if (stp)                    ch_addr[g] <= ch_addr[g] + 1'b1;

        if (hit && wr_field == FLD_CNT) begin
          ch_cnt[g] <= wr_data[CW-1:0];
          ch_dir[g] <= wr_data[DW-1];
          ch_en[g]  <= 1'b1;
        end else if (stp) begin
          ch_cnt[g] <= ch_cnt[g] - 1'b1;
          if (ch_cnt[g] == '0) ch_en[g] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int AW          = 16,
  parameter int CW          = 14,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IW    = $clog2(NCH),
  localparam int LOW_W = AW / 2,
  localparam int HI_W  = AW - LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   drq,
  input  logic             hlda,
  input  logic             ready,
  input  logic             prog_we,
  input  logic [IW-1:0]    prog_chan,
  input  logic [1:0]       prog_field,
  input  logic [DW-1:0]    prog_wdata,
  output logic             hrq,
  output logic [NCH-1:0]   dack,
  output logic             mem_rd_n,
  output logic             mem_wr_n,
  output logic [LOW_W-1:0] addr_lo,
  output logic [HI_W-1:0]  upper_out,
  output logic             adstb,
  output logic             tc
);
  arb_state_t             state;
  logic [NCH-1:0]         req_s, pend, pick_pend, gnt_oh;
  logic [IW-1:0]          gnt, rot_base, pick_base, pick_idx, gnt_next;
  logic                   pick_any, rot_mode, up_valid;
  logic [HI_W-1:0]        last_up, cur_hi;
  logic [AW-1:0]          cur_addr;
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][CW-1:0] ch_cnt;
  logic [NCH-1:0]         ch_en, ch_dir;
  logic                   in_addr, in_xfer, done, last_xfer;

  dma_req_sync #(.N(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(drq), .sync_out(req_s));

  dma_chan_regs #(.N(NCH), .AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prog_we), .wr_chan(prog_chan), .wr_field(prog_field), .wr_data(prog_wdata),
    .step(done), .step_chan(gnt),
    .ch_addr(ch_addr), .ch_cnt(ch_cnt), .ch_en(ch_en), .ch_dir(ch_dir));

  assign in_addr   = (state == ST_ADDR);
  assign in_xfer   = (state == ST_XFER);
  assign done      = in_xfer && ready;
  assign last_xfer = (ch_cnt[gnt] == '0);
  assign gnt_oh    = NCH'(1) << gnt;
  assign gnt_next  = (int'(gnt) == NCH - 1) ? '0 : gnt + 1'b1;
  assign pend      = req_s & ch_en;
  // Next grant at completion sees the finished channel's enable and new base.
  assign pick_pend = pend & ~((done && last_xfer) ? gnt_oh : '0);
  assign pick_base = (done && rot_mode) ? gnt_next : rot_base;

  dma_prio_pick #(.N(NCH)) u_pick (
    .pend(pick_pend), .base(pick_base), .any(pick_any), .idx(pick_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      gnt      <= '0;
      rot_mode <= 1'b0;
      rot_base <= '0;
      up_valid <= 1'b0;
      last_up  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          up_valid <= 1'b0;
          if (|pend) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!(|pend)) state <= ST_IDLE;
          else if (hlda) begin
            gnt   <= pick_idx;
            state <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          up_valid <= 1'b1;
          last_up  <= cur_hi;
          state    <= ST_XFER;
        end
        ST_XFER: begin
          if (done) begin
            if (rot_mode) rot_base <= gnt_next;
            if (pick_any) begin
              gnt   <= pick_idx;
              state <= ST_ADDR;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (prog_we && prog_field == FLD_MODE) begin
        rot_mode <= prog_wdata[0];
        rot_base <= '0;
      end
    end
  end

  assign cur_addr  = ch_addr[gnt];
  assign cur_hi    = cur_addr[AW-1:LOW_W];
  assign hrq       = (state != ST_IDLE);
  assign dack      = (in_addr || in_xfer) ? gnt_oh : '0;
  assign mem_rd_n  = !(in_xfer && !ch_dir[gnt]);
  assign mem_wr_n  = !(in_xfer && ch_dir[gnt]);
  assign addr_lo   = (in_addr || in_xfer) ? cur_addr[LOW_W-1:0] : '0;
  assign upper_out = in_addr ? cur_hi : '0;
  assign adstb     = in_addr && (!up_valid || cur_hi != last_up);
  assign tc        = done && last_xfer;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NCH = 4,
  parameter int IW  = 2,
  parameter int LW  = 8,
  parameter int HW  = 8,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] drq,
  input logic           hlda,
  input logic           ready,
  input logic           prog_we,
  input logic [IW-1:0]  prog_chan,
  input logic [1:0]     prog_field,
  input logic [DW-1:0]  prog_wdata,
  input logic           hrq,
  input logic [NCH-1:0] dack,
  input logic           mem_rd_n,
  input logic           mem_wr_n,
  input logic [LW-1:0]  addr_lo,
  input logic [HW-1:0]  upper_out,
  input logic           adstb,
  input logic           tc
);
  logic strobe;
  assign strobe = !mem_rd_n || !mem_wr_n;

  a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrq) |-> $past(|drq, 2));
  a_r2_grant_needs_hlda: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dack) |-> $past(hlda));
  a_r5_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
  a_r5_strobe_with_dack: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (|dack) && !(!mem_rd_n && !mem_wr_n));
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !ready) |=> strobe && $stable(dack) && $stable(addr_lo)
                           && $stable(mem_rd_n) && $stable(mem_wr_n));
  a_r8_tc_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> strobe && ready);
  a_r9_hrq_covers_dack: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> hrq);
  a_r10_adstb_in_addr_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |-> (|dack) && !strobe);
endmodule

bind dma_req_arbiter dma_arb_checker #(.NCH(NCH), .IW(IW), .LW(LOW_W), .HW(HI_W), .DW(DW))
  i_chk (.*);

// File: tb/test_dma_req_arbiter.sv
`timescale 1ns/1ps
module test_dma_req_arbiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] drq = '0;
  logic hlda = 1'b0, ready = 1'b1, prog_we = 1'b0;
  logic [1:0] prog_chan = '0, prog_field = '0;
  logic [15:0] prog_wdata = '0;
  logic hrq, mem_rd_n, mem_wr_n, adstb, tc;
  logic [3:0] dack;
  logic [7:0] addr_lo, upper_out;

  always #4 clk = ~clk;

  dma_req_arbiter i_dma_req_arbiter (
    .clk(clk), .rst_n(rst_n), .drq(drq), .hlda(hlda), .ready(ready),
    .prog_we(prog_we), .prog_chan(prog_chan), .prog_field(prog_field),
    .prog_wdata(prog_wdata), .hrq(hrq), .dack(dack), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .addr_lo(addr_lo), .upper_out(upper_out),
    .adstb(adstb), .tc(tc));

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_addr [4];
  int m_cnt [4];
  bit m_en [4], m_dir [4];
  int m_base = 0;
  bit m_rot = 0, m_upv = 0;
  logic [7:0] m_last = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pick(input bit [3:0] p, input int base);
    for (int i = 0; i < 4; i++)
      if (p[(base + i) % 4]) return (base + i) % 4;
    return -1;
  endfunction

  function automatic bit [3:0] pend_m(input bit [3:0] mask);
    bit [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = mask[i] && m_en[i];
    return r;
  endfunction

  task automatic wr(input logic [1:0] ch, input logic [1:0] fld, input logic [15:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_chan = ch; prog_field = fld; prog_wdata = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic prog_ch(input int ch, input logic [15:0] a, input int cnt, input bit dir);
    wr(2'(ch), 2'd0, a);
    wr(2'(ch), 2'd1, {dir, 1'b0, 14'(cnt)});
    m_addr[ch] = a; m_cnt[ch] = cnt; m_en[ch] = 1; m_dir[ch] = dir;
  endtask

  task automatic set_mode(input bit rot);
    wr(2'd0, 2'd2, {15'd0, rot});
    m_rot = rot; m_base = 0;
  endtask

  // Runs one scenario to completion, checking every cycle against the model.
  task automatic run(input bit [3:0] mask, input int rdy_pct);
    int cur = 0;
    bit exp_idle = 0;
    logic [7:0] hi;
    drq = mask;
    if (pend_m(mask) == 0) return;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      ready = ($urandom_range(99) < rdy_pct);
      #1;
      if (exp_idle) begin
        chk(hrq == 1'b0 && dack == 4'd0, "R9", "hrq after last transfer", hrq, 0);
        break;
      end
      if (dack != 0 && mem_rd_n && mem_wr_n) begin
        cur = pick(pend_m(mask), m_base);
        chk(dack == 4'(1 << cur), m_rot ? "R4" : "R3", "granted dack", dack, 1 << cur);
        chk(addr_lo == m_addr[cur][7:0], "R7", "address low byte", addr_lo, m_addr[cur][7:0]);
        hi = m_addr[cur][15:8];
        chk(adstb == (!m_upv || hi != m_last), "R10", "adstb", adstb, (!m_upv || hi != m_last));
        if (adstb) chk(upper_out == hi, "R10", "upper byte", upper_out, hi);
        m_upv = 1; m_last = hi;
      end else if (!mem_rd_n || !mem_wr_n) begin
        chk(!mem_wr_n == m_dir[cur] && mem_rd_n != mem_wr_n, "R11", "strobe direction",
            {mem_rd_n, mem_wr_n}, m_dir[cur] ? 2 : 1);
        chk(dack == 4'(1 << cur), "R5", "dack during strobe", dack, 1 << cur);
        chk(addr_lo == m_addr[cur][7:0], "R6", "address held in cycle", addr_lo, m_addr[cur][7:0]);
        chk(tc == (ready && m_cnt[cur] == 0), "R8", "terminal count", tc, ready && m_cnt[cur] == 0);
        if (ready) begin
          m_addr[cur]++;
          if (m_cnt[cur] == 0) begin m_en[cur] = 0; m_cnt[cur] = 16383; end
          else m_cnt[cur]--;
          if (m_rot) m_base = (cur + 1) % 4;
          if (pend_m(mask) == 0) exp_idle = 1;
        end
      end else begin
        chk(tc == 1'b0, "R8", "tc outside transfer", tc, 0);
      end
    end
    chk(exp_idle, "R9", "scenario completed", exp_idle, 1);
    ready = 1'b1;
    drq = '0;
    m_upv = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hrq == 0 && dack == 0 && mem_rd_n && mem_wr_n && !adstb && !tc,
        "R5", "reset outputs", {hrq, dack, mem_rd_n, mem_wr_n}, 4'b0011);

    // Directed: sync delay, hold handshake, fixed priority over all channels.
    for (int c = 0; c < 4; c++) prog_ch(c, 16'h1000 * c + 16'h10, 1, c[0]);
    wr(2'd1, 2'd3, 16'hFFFF);   // R11: field 3 ignored; run shows ch1 unchanged
    drq = 4'hF;
    @(negedge clk); chk(hrq == 0, "R1", "hrq after 1 edge", hrq, 0);
    @(negedge clk); chk(hrq == 0, "R1", "hrq after 2 edges", hrq, 0);
    @(negedge clk); chk(hrq == 1, "R1", "hrq after 3 edges", hrq, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(dack == 0 && mem_rd_n && mem_wr_n, "R2", "no grant without hlda", dack, 0);
    end
    hlda = 1'b1;
    run(4'hF, 100);

    // Rotating mode, all channels, with wait states.
    set_mode(1);
    for (int c = 0; c < 4; c++) prog_ch(c, 16'h2000 + 16'(c * 64), 2, 1'b0);
    run(4'hF, 60);

    // Boundary: single-transfer channel then an upper-byte crossing.
    set_mode(0);
    for (int c = 0; c < 4; c++) prog_ch(c, 16'h3000, 5, 1'b1);
    prog_ch(1, 16'h1200, 0, 1'b0);
    prog_ch(2, 16'h00FE, 3, 1'b1);
    run(4'b0110, 100);

    // Random scenarios.
    for (int s = 0; s < 30; s++) begin
      set_mode(1'($urandom_range(1)));
      for (int c = 0; c < 4; c++)
        prog_ch(c, 16'($urandom), $urandom_range(5), 1'($urandom_range(1)));
      run(4'($urandom_range(1, 15)), $urandom_range(30, 100));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule